// File: doc/BRIEF.md
# Serial Delay-Code Configuration Slave

This block receives configuration bytes over a three-wire, write-only serial link (an active-low frame enable, a serial clock and a serial data line) and holds the settings for a three-channel skew-compensation datapath: one 5-bit delay code per colour channel and one 4-bit slicer-level code for the edge-comparison circuitry. The serial pins are asynchronous to the block. They are resynchronised and oversampled by the system clock, and every bit is taken on a detected falling edge of the serial clock.

A frame opens when the enable goes low. Bytes then follow back to back, most significant bit first, and no re-framing happens between them. The top bit of each byte is a guard bit that must be zero. The next two bits pick the destination, and the low five bits carry the payload. Each accepted byte produces a one-cycle write pulse that a downstream offset-calibration sequencer can use. A chip-enable input blanks the delay outputs during standby without losing the stored codes. A parameter selects a short-range variant that limits delay codes to 15.

Top module: `skew_cfg_serial_slave`

## Requirements
- R1: After reset all delay codes and the slicer code are 0 and the write pulse is low.
- R2: While the frame enable is low, each falling edge of the serial clock shifts in one data bit, most significant bit first. A completed byte b7..b0 with b7=0 writes b4..b0 to the red code when b6:b5=01, to the green code when b6:b5=10 and to the blue code when b6:b5=11.
- R3: After eight captured bits the next falling edge starts a new byte, so several bytes may be written in one frame.
- R4: A falling edge of the frame enable discards any partly received byte, and the next byte is framed from its first bit.
- R5: A completed byte with b7=1 changes no register and raises no write pulse.
- R6: A byte with b7:b5=000 addresses the test register and writes b4..b1 (b1 as LSB) to the slicer code, but only if b0=0. With b0=1 the byte is discarded.
- R7: A register changes only when the eighth bit of a byte is captured. The outputs and a one-cycle write pulse appear on the fourth rising system-clock edge after the serial-clock falling edge is presented (two synchroniser stages).
- R8: Serial-clock edges while the frame enable is high have no effect.
- R9: While chip_en is low the three delay outputs read 0. The stored codes are kept, still accept writes, and reappear when chip_en returns high.
- R10: With SHORT_RANGE=1 a delay code above 15 is stored as 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Standby control, low blanks the delay outputs |
| ser_en_n | input | 1 | Active-low frame enable |
| ser_clk | input | 1 | Serial clock, data taken on falling edges |
| ser_dat | input | 1 | Serial data, MSB first |
| dly_red | output | 5 | Red channel delay code |
| dly_grn | output | 5 | Green channel delay code |
| dly_blu | output | 5 | Blue channel delay code |
| slice_lvl | output | 4 | Slicer-level code from the test register |
| wr_pulse | output | 1 | One-cycle pulse per accepted byte |

## Verification
A byte can complete and be stored in the same cycle that chip_en holds the delay outputs blanked. The bench provokes this by finishing a blue write while chip_en is low. It judges the result by checking that the outputs stay 0 in that cycle, that the write pulse still fires, and that the new code appears as soon as chip_en rises. A behavioural model driven by the same pin events predicts every output on every clock, three cycles delayed, for both the full-range instance and the short-range instance.

// File: rtl/skew_cfg_pkg.sv
package skew_cfg_pkg;
   localparam int WORD_W    = 8;
   localparam int CODE_W    = WORD_W - 3;
   localparam int SLICE_W   = CODE_W - 1;
   localparam int SHORT_MAX = 15;
   localparam int CNT_W     = $clog2(WORD_W);

   typedef enum logic [1:0] {
      TGT_TEST = 2'b00,
      TGT_RED  = 2'b01,
      TGT_GRN  = 2'b10,
      TGT_BLU  = 2'b11
   } tgt_e;
endpackage

// File: rtl/skew_cfg_sync.sv
module skew_cfg_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage_q[k] <= RST_VAL;
      end else begin
         stage_q[0] <= d;
         for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/skew_cfg_framer.sv
module skew_cfg_framer import skew_cfg_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n_s,
   input  logic              sclk_s,
   input  logic              sdat_s,
   output logic              word_vld,
   output logic [WORD_W-1:0] word
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   logic              en_n_d, sclk_d;
   logic              en_fall, sclk_fall, take_bit;
   logic [CNT_W-1:0]  bit_cnt;
   logic [WORD_W-1:0] shift_q;
   logic [WORD_W-1:0] shift_nx;

   assign en_fall   = en_n_d & ~en_n_s;
   assign sclk_fall = sclk_d & ~sclk_s;
   assign take_bit  = sclk_fall & ~en_n_s;
   assign shift_nx  = {shift_q[WORD_W-2:0], sdat_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_n_d   <= 1'b1;
         sclk_d   <= 1'b1;
         bit_cnt  <= '0;
         shift_q  <= '0;
         word_vld <= 1'b0;
         word     <= '0;
      end else begin
         en_n_d   <= en_n_s;
         sclk_d   <= sclk_s;
         word_vld <= 1'b0;
         if (en_fall) begin
            bit_cnt <= '0;
            shift_q <= '0;
         end else if (take_bit) begin
            shift_q <= shift_nx;
            if (bit_cnt == LAST_BIT) begin
               bit_cnt  <= '0;
               word_vld <= 1'b1;
               word     <= shift_nx;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      en_fall |=> (bit_cnt == '0)); // R4
   AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      en_n_s |=> $stable(bit_cnt)); // R8
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld); // R7
endmodule

// File: rtl/skew_cfg_bank.sv
module skew_cfg_bank import skew_cfg_pkg::*; #(
   parameter bit SHORT_RANGE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_vld,
   input  logic [WORD_W-1:0]  word,
   output logic [CODE_W-1:0]  dly_red,
   output logic [CODE_W-1:0]  dly_grn,
   output logic [CODE_W-1:0]  dly_blu,
   output logic [SLICE_W-1:0] slice_lvl,
   output logic               wr_pulse
);
   logic [CODE_W-1:0] code_raw, code_eff;
   tgt_e              tgt;
   logic              guard_bit, pad_ok, accept;

   assign code_raw  = word[CODE_W-1:0];
   assign tgt       = tgt_e'(word[WORD_W-2 -: 2]);
   assign guard_bit = word[WORD_W-1];
   assign pad_ok    = (tgt != TGT_TEST) | ~word[0];
   assign accept    = word_vld & ~guard_bit & pad_ok;

   if (SHORT_RANGE) begin : g_short
      assign code_eff = (code_raw > CODE_W'(SHORT_MAX)) ? CODE_W'(SHORT_MAX) : code_raw;

      AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (dly_red <= CODE_W'(SHORT_MAX)) && (dly_grn <= CODE_W'(SHORT_MAX))
         && (dly_blu <= CODE_W'(SHORT_MAX))); // R10
   end else begin : g_full
      assign code_eff = code_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_red   <= '0;
         dly_grn   <= '0;
         dly_blu   <= '0;
         slice_lvl <= '0;
         wr_pulse  <= 1'b0;
      end else begin
         wr_pulse <= accept;
         if (accept) begin
            unique case (tgt)
               TGT_RED:  dly_red   <= code_eff;
               TGT_GRN:  dly_grn   <= code_eff;
               TGT_BLU:  dly_blu   <= code_eff;
               TGT_TEST: slice_lvl <= word[SLICE_W:1];
               default:  ;
            endcase
         end
      end
   end

   AST_HOLD_BETWEEN_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> ($stable(dly_red) && $stable(dly_grn) && $stable(dly_blu)
                     && $stable(slice_lvl) && !wr_pulse)); // R7
   AST_GUARD_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && word[WORD_W-1]) |=> (!wr_pulse && $stable(dly_red)
         && $stable(dly_grn) && $stable(dly_blu) && $stable(slice_lvl))); // R5
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse |=> !wr_pulse); // R7
   AST_TEST_PAD_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && word[WORD_W-1 -: 3] == 3'b000 && word[0]) |=>
         (!wr_pulse && $stable(slice_lvl))); // R6
endmodule

// File: rtl/skew_cfg_serial_slave.sv
module skew_cfg_serial_slave import skew_cfg_pkg::*; #(
   parameter int SYNC_STAGES = 2,
   parameter bit SHORT_RANGE = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chip_en,
   input  logic               ser_en_n,
   input  logic               ser_clk,
   input  logic               ser_dat,
   output logic [CODE_W-1:0]  dly_red,
   output logic [CODE_W-1:0]  dly_grn,
   output logic [CODE_W-1:0]  dly_blu,
   output logic [SLICE_W-1:0] slice_lvl,
   output logic               wr_pulse
);
   localparam int PIN_W = 3;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WORD_W != 8) begin : g_bad_word
      $error("word layout assumes 8 bits");
   end

   logic [PIN_W-1:0]  pins_s;
   logic              word_vld;
   logic [WORD_W-1:0] word;
   logic [CODE_W-1:0] red_q, grn_q, blu_q;

   skew_cfg_sync #(
      .WIDTH   (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b110)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_en_n, ser_clk, ser_dat}),
      .q     (pins_s)
   );

   skew_cfg_framer i_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_n_s   (pins_s[2]),
      .sclk_s   (pins_s[1]),
      .sdat_s   (pins_s[0]),
      .word_vld (word_vld),
      .word     (word)
   );

   skew_cfg_bank #(
      .SHORT_RANGE (SHORT_RANGE)
   ) i_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_vld  (word_vld),
      .word      (word),
      .dly_red   (red_q),
      .dly_grn   (grn_q),
      .dly_blu   (blu_q),
      .slice_lvl (slice_lvl),
      .wr_pulse  (wr_pulse)
   );

   assign dly_red = chip_en ? red_q : '0;
   assign dly_grn = chip_en ? grn_q : '0;
   assign dly_blu = chip_en ? blu_q : '0;

   AST_STANDBY_RETAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_en && !word_vld) |=> ($stable(red_q) && $stable(grn_q) && $stable(blu_q))); // R9
endmodule

// File: tb/test_skew_cfg_serial_slave.sv
module test_skew_cfg_serial_slave;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam int WD_LIMIT   = 150000;

   typedef struct packed {
      logic [4:0] r;
      logic [4:0] g;
      logic [4:0] b;
      logic [3:0] s;
      logic       p;
   } snap_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_en = 1'b1;
   logic ser_en_n = 1'b1;
   logic ser_clk = 1'b1;
   logic ser_dat = 1'b0;
   logic [4:0] d_r, d_g, d_b, c_r, c_g, c_b;
   logic [3:0] d_s, c_s;
   logic       d_p, c_p;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit chk_on = 1'b0;

   logic [4:0] m_r = '0, m_g = '0, m_b = '0;
   logic [3:0] m_s = '0;
   logic       m_p = 1'b0;
   logic       m_en_n = 1'b1;
   int         m_cnt = 0;
   logic [7:0] m_word = '0;
   snap_t      hist[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   skew_cfg_serial_slave i_skew_cfg_serial_slave (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ser_en_n(ser_en_n),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .dly_red(d_r), .dly_grn(d_g),
      .dly_blu(d_b), .slice_lvl(d_s), .wr_pulse(d_p));

   skew_cfg_serial_slave #(.SHORT_RANGE(1'b1)) i_skew_cfg_serial_slave_short (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ser_en_n(ser_en_n),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .dly_red(c_r), .dly_grn(c_g),
      .dly_blu(c_b), .slice_lvl(c_s), .wr_pulse(c_p));

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int clamp15(input logic [4:0] v);
      return (v > 5'd15) ? 15 : int'(v);
   endfunction

   // Behavioural reference: the serial protocol applied at pin-event time
   task automatic model_bit(input logic b);
      if (m_en_n) return;                       // R8: edges outside a frame ignored
      m_word = {m_word[6:0], b};
      m_cnt++;
      if (m_cnt == 8) begin
         m_cnt = 0;
         if (!m_word[7]) begin                  // R5: guard bit must be 0
            case (m_word[6:5])
               2'b01: begin m_r = m_word[4:0]; m_p = 1'b1; end
               2'b10: begin m_g = m_word[4:0]; m_p = 1'b1; end
               2'b11: begin m_b = m_word[4:0]; m_p = 1'b1; end
               default: if (!m_word[0]) begin m_s = m_word[4:1]; m_p = 1'b1; end
            endcase
         end
      end
   endtask

   // Per-cycle comparison against the model delayed by the pipeline latency
   always @(negedge clk) begin
      snap_t e;
      hist.push_back('{r: m_r, g: m_g, b: m_b, s: m_s, p: m_p});
      m_p = 1'b0;
      if (hist.size() > LAT) begin
         e = hist.pop_front();
         if (chk_on) begin
            chk("R2", "red",    int'(d_r), chip_en ? int'(e.r) : 0);
            chk("R2", "green",  int'(d_g), chip_en ? int'(e.g) : 0);
            chk("R2", "blue",   int'(d_b), chip_en ? int'(e.b) : 0);
            chk("R6", "slice",  int'(d_s), int'(e.s));
            chk("R7", "pulse",  int'(d_p), int'(e.p));
            chk("R10", "short red",  int'(c_r), chip_en ? clamp15(e.r) : 0);
            chk("R10", "short grn",  int'(c_g), chip_en ? clamp15(e.g) : 0);
            chk("R10", "short blu",  int'(c_b), chip_en ? clamp15(e.b) : 0);
            chk("R10", "short pulse", int'(c_p), int'(e.p));
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
         fails++;
         checks++;
         $display("FAIL R3 watchdog expired actual=%0d expected<=%0d", cyc, WD_LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic send_bit(input logic b);
      step();
      ser_dat = b;
      repeat (3) step();
      ser_clk = 1'b0;
      model_bit(b);
      repeat (3) step();
      ser_clk = 1'b1;
   endtask

   task automatic send_word(input logic [7:0] w);
      for (int i = 7; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic frame_open();
      step();
      ser_en_n = 1'b0;
      m_en_n = 1'b0;
      m_cnt = 0;
      m_word = '0;
      repeat (3) step();
   endtask

   task automatic frame_close();
      repeat (2) step();
      ser_en_n = 1'b1;
      m_en_n = 1'b1;
      repeat (6) step();
   endtask

   initial begin
      repeat (4) step();
      // R1: reset state observed while reset is held
      chk("R1", "red at reset",   int'(d_r), 0);
      chk("R1", "blue at reset",  int'(d_b), 0);
      chk("R1", "slice at reset", int'(d_s), 0);
      chk("R1", "pulse at reset", int'(d_p), 0);
      rst_n = 1'b1;
      chk_on = 1'b1;
      repeat (4) step();

      // R2: one red write, code 21 (also clamped to 15 in the short variant, R10)
      frame_open(); send_word(8'b0_01_10101); frame_close();
      // R3: three bytes in one frame
      frame_open();
      send_word(8'b0_01_00011);
      send_word(8'b0_10_11111);
      send_word(8'b0_11_01110);
      frame_close();
      // R6: test register write, then one with a nonzero pad bit
      frame_open(); send_word(8'b000_1011_0); send_word(8'b000_0110_1); frame_close();
      // R5: guard bit set, discarded
      frame_open(); send_word(8'b1_01_00001); frame_close();
      // R4: five stray bits, reframe, then a clean green write
      frame_open();
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      frame_close();
      frame_open(); send_word(8'b0_10_00100); frame_close();
      // R8: serial clocks with the frame enable high
      for (int i = 0; i < 8; i++) send_bit(1'b1);
      frame_open(); send_word(8'b0_11_10000); frame_close();
      // R9: standby blanks outputs; a blue write lands during standby
      step();
      chip_en = 1'b0;
      repeat (2) step();
      chk("R9", "red blanked",  int'(d_r), 0);
      chk("R9", "green blanked", int'(d_g), 0);
      frame_open(); send_word(8'b0_11_00110); frame_close();
      chk("R9", "blue blanked after write", int'(d_b), 0);
      step();
      chip_en = 1'b1;
      repeat (2) step();
      chk("R9", "blue restored", int'(d_b), 6);
      chk("R9", "green restored", int'(d_g), 4);
      // R2 and R3: a final full stream with unsorted values
      frame_open();
      send_word(8'b0_11_11001);
      send_word(8'b0_01_00000);
      send_word(8'b000_0001_0);
      frame_close();
      repeat (8) step();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule